// File: doc/BRIEF.md
# Serial Address-Data Register Loader

This block is the control-register front end of a sensor-style device. A host shifts 8-bit frames into a temporary shift register on a serial clock. That clock is unrelated to the system clock. Each frame is a register address followed by a data value. Raising a load strobe commits the held frame into a bank of small registers on the system clock. Every register in the bank is brought out in parallel.

The block also qualifies a capture-start strobe. A start strobe of any length yields exactly one system-clock start pulse, timed from the end of the strobe. With that pulse comes a counter preload value copied from a fixed register of the bank. Both strobes pass through two-flop synchronizers. The host must keep the frame steady while the load strobe is high. Reset is asynchronous.

Top module: `addr_data_loader`

## Requirements
- R1: Frames are shifted in on the rising edge of `ser_clk`, most significant bit first. The first four bits are the address (A3..A0) and the last four bits are the data (D3..D0).
- R2: A load strobe writes the data of the held frame into the register selected by its address. Register k appears on `regs_flat[4k+3:4k]`, and no other register changes.
- R3: A load strobe held high across many system-clock edges writes once only, using the frame present at its start. Frames shifted in while it stays high are not written.
- R4: The asynchronous reset clears all 16 registers to 0000 and drives `start_pulse` and `cnt_preload` to 0.
- R5: Each high period of `start_req` yields exactly one `start_pulse`, one cycle wide. The pulse follows the end of the strobe, so a long strobe acts on its last high sample.
- R6: When `start_pulse` is high, `cnt_preload` holds the content of register 15. It does not change at any other time.
- R7: Shifting frames without a load strobe leaves the register bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, unrelated to `clk` |
| ser_din | input | 1 | Serial frame data |
| load_req | input | 1 | Load strobe, asynchronous to `clk` |
| start_req | input | 1 | Capture-start strobe |
| regs_flat | output | 64 | All 16 registers; register k at bits 4k+3:4k |
| start_pulse | output | 1 | One-cycle start pulse |
| cnt_preload | output | 4 | Counter preload captured with the start pulse |

## Verification
A directed frame with a distinctive address and data value shows whether the bit order or the address/data split is wrong. A directed walk over all 16 addresses is followed by random frames, which shows whether writes land in the correct register without disturbing the others. The bench also shifts a second frame while the load strobe is still high and shifts frames with no strobe at all; this separates a single edge-detected write from level-sensitive writing. Short and long start strobes check that exactly one pulse follows the end of each strobe. An asynchronous reset applied in the middle of the run shows that the bank really clears.

// File: rtl/addr_data_loader.sv
module addr_data_loader #(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter int PRE_IDX = 15,
  localparam int NREG = 1 << AW,
  localparam int FW = AW + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  input  logic                 load_req,
  input  logic                 start_req,
  output logic [NREG*DW-1:0]   regs_flat,
  output logic                 start_pulse,
  output logic [DW-1:0]        cnt_preload
);

  logic [FW-1:0] frame_q;
  logic [DW-1:0] bank [NREG];
  logic ld_s1, ld_s2, ld_d;
  logic st_s1, st_s2, st_d;
  logic wr_en, st_fall;

  always_ff @(posedge ser_clk or negedge rst_n)
    if (!rst_n) frame_q <= '0;
    else        frame_q <= {frame_q[FW-2:0], ser_din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ld_s1, ld_s2, ld_d, st_s1, st_s2, st_d} <= '0;
    else begin
      {ld_d, ld_s2, ld_s1} <= {ld_s2, ld_s1, load_req};
      {st_d, st_s2, st_s1} <= {st_s2, st_s1, start_req};
    end

  assign wr_en   = ld_s2 & ~ld_d;
  assign st_fall = ~st_s2 & st_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[frame_q[FW-1:DW]] <= frame_q[DW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_pulse <= 1'b0;
      cnt_preload <= '0;
    end else begin
      start_pulse <= st_fall;
      if (st_fall) cnt_preload <= bank[PRE_IDX];
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_flat[g*DW +: DW] = bank[g];
  end

  // R3
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);
  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank[$past(frame_q[FW-1:DW])] == $past(frame_q[DW-1:0]));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse);
  // R5
  pulse_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> !$past(st_s2));
  // R6
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_preload) |-> start_pulse);

endmodule

// File: tb/addr_data_loader_test.sv
module addr_data_loader_test;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, load_req = 0, start_req = 0;
  logic [63:0] regs_flat;
  logic start_pulse;
  logic [3:0] cnt_preload;
  logic [3:0] exp_r [16];
  int n_chk = 0, n_bad = 0, pulse_cnt = 0;
  logic [3:0] seen_pre;

  addr_data_loader uut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_req(load_req), .start_req(start_req), .regs_flat(regs_flat),
    .start_pulse(start_pulse), .cnt_preload(cnt_preload));

  always #4 clk = ~clk;

  always @(negedge clk) if (start_pulse) begin pulse_cnt++; seen_pre = cnt_preload; end

  function automatic logic [63:0] model_flat();
    logic [63:0] v;
    for (int i = 0; i < 16; i++) v[i*4 +: 4] = exp_r[i];
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic shift_frame(logic [3:0] a, logic [3:0] d);
    logic [7:0] f = {a, d};
    for (int i = 7; i >= 0; i--) begin
      ser_din = f[i]; #11 ser_clk = 1; #11 ser_clk = 0;
    end
  endtask

  task automatic do_load(logic [3:0] a, logic [3:0] d, int hold);
    shift_frame(a, d);
    @(negedge clk) load_req = 1;
    repeat (hold) @(negedge clk);
    load_req = 0;
    repeat (4) @(negedge clk);
    exp_r[a] = d;
  endtask

  task automatic do_start(int hold, string req);
    pulse_cnt = 0;
    @(negedge clk) start_req = 1;
    repeat (hold) @(negedge clk);
    chk(req, 64'(pulse_cnt), 64'd0);
    start_req = 0;
    repeat (6) @(negedge clk);
    chk(req, 64'(pulse_cnt), 64'd1);
    chk("R6", 64'(seen_pre), 64'(exp_r[15]));
    chk(req, 64'(start_pulse), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] a, d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) exp_r[i] = 4'd0;
    #20;
    chk("R4", regs_flat, 64'd0);
    chk("R4", {59'd0, start_pulse, cnt_preload}, 64'd0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);
    // R1: distinctive frame, address 0xA data 0x5
    do_load(4'hA, 4'h5, 1);
    chk("R1", regs_flat, model_flat());
    // R2: walk all addresses
    for (int i = 0; i < 16; i++) begin
      do_load(i[3:0], 4'(15 - i), 1);
      chk("R2", regs_flat, model_flat());
    end
    // R2: random frames with random strobe lengths
    for (int i = 0; i < 40; i++) begin
      a = 4'($urandom); d = 4'($urandom);
      do_load(a, d, 1 + int'($urandom % 5));
      chk("R2", regs_flat, model_flat());
    end
    // R7: frames without load
    for (int i = 0; i < 4; i++) shift_frame(4'(i), 4'(~exp_r[i]));
    repeat (4) @(negedge clk);
    chk("R7", regs_flat, model_flat());
    // R3: second frame shifted during a long strobe
    shift_frame(4'h3, 4'h9);
    @(negedge clk) load_req = 1;
    repeat (6) @(negedge clk);
    exp_r[3] = 4'h9;
    shift_frame(4'h3, 4'h6);
    shift_frame(4'h7, 4'h1);
    repeat (3) @(negedge clk);
    load_req = 0;
    repeat (5) @(negedge clk);
    chk("R3", regs_flat, model_flat());
    // R5/R6: short and long start strobes
    do_load(4'hF, 4'hC, 1);
    do_start(1, "R5");
    do_load(4'hF, 4'h3, 2);
    do_start(12, "R5");
    chk("R6", 64'(cnt_preload), 64'h3);
    do_load(4'hF, 4'h8, 1);
    repeat (4) @(negedge clk);
    chk("R6", 64'(cnt_preload), 64'h3);
    // R4: asynchronous reset mid-run
    #3 rst_n = 0;
    #2;
    for (int i = 0; i < 16; i++) exp_r[i] = 4'd0;
    chk("R4", regs_flat, model_flat());
    chk("R4", {59'd0, start_pulse, cnt_preload}, 64'd0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);
    do_load(4'h6, 4'hE, 1);
    chk("R2", regs_flat, model_flat());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule